// File: doc/BRIEF.md
# Receive Destination Address Filter

This block looks at the first six bytes of each received frame, which form the destination address, and classifies the frame. Bytes arrive one per clock on `in_byte` and are qualified by `in_valid`. `in_sof` marks the first destination byte, which is the first byte after the start delimiter. `in_eof` marks the last byte of the frame. The block compares these bytes against one programmed station address. It reports whether the address matched the station, whether it is a group (multicast) address, and whether it is the all-ones broadcast address.

Software programs the station address through two 32-bit words. The low word holds the first four bytes seen on the wire, with the earliest byte in the least significant position. The high word holds the last two bytes and a valid bit. A result strobe with its flags appears on the cycle after the sixth destination byte is accepted. Later bytes, as well as frames too short to carry a full address, leave the outputs quiet.

Top module: `rx_dest_filter`

## Requirements
- R1: Byte k of the address (k = 1 for the first byte on the wire) is stored in bits [8k-1:8k-8] of the low word for k = 1..4. Byte 5 is stored in bits 7:0 of the high word and byte 6 in bits 15:8. For example, the wire sequence 00 AA 00 11 22 33 matches low word 0x1100AA00 with high word 0x80003322.
- R2: Bit 31 of the high word is the station-valid bit. While it is 0, `res_ucast` is never asserted.
- R3: `res_ucast` is 1 with the strobe exactly when the station is valid and all six destination bytes equal the stored bytes in wire order. A difference in any single byte or bit clears it.
- R4: `res_mcast` equals bit 0 of the first destination byte.
- R5: `res_bcast` is 1 only when all six destination bytes are 0xFF. A broadcast frame therefore also has `res_mcast` set.
- R6: `res_valid` pulses for exactly one cycle, on the cycle after the clock edge that accepts the sixth destination byte. The three flags are 0 whenever `res_valid` is 0.
- R7: A frame whose `in_eof` byte comes before the sixth destination byte produces no strobe. A frame that ends on the sixth byte still produces one.
- R8: A byte with `in_valid` and `in_sof` both high always starts a new address as byte 1, even in the middle of an unfinished frame.
- R9: Cycles with `in_valid` low do not advance the byte count. Bytes after the sixth are ignored. Valid bytes that arrive without `in_sof` after a frame has ended are ignored.
- R10: Synchronous active-high `rst` clears all outputs and clears both address words, including the valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_lo | input | 1 | Write `cfg_wdata` to the low address word |
| cfg_wr_hi | input | 1 | Write `cfg_wdata` to the high address word |
| cfg_wdata | input | 32 | Address word write data |
| in_valid | input | 1 | Frame byte qualifier |
| in_sof | input | 1 | Current byte is the first destination byte |
| in_eof | input | 1 | Current byte is the last byte of the frame |
| in_byte | input | 8 | Frame byte |
| res_valid | output | 1 | Classification strobe |
| res_ucast | output | 1 | Destination equals the valid station address |
| res_mcast | output | 1 | Destination is a group address |
| res_bcast | output | 1 | Destination is all ones |

## Verification
The assertions check, on every cycle, the properties that depend on no particular frame content. They confirm that the strobe is a single cycle wide and follows an accepted byte, that the flags stay low between strobes, that broadcast implies multicast, that a cleared valid bit blocks a station match, and that the outputs are quiet after reset. Only the bench's scenarios can show the rest. These are the wire-order byte mapping of the two words, the per-byte mismatch behaviour, truncated frames, restarts in the middle of a frame, gaps, and trailing or stray bytes being ignored. The bench checks these against a model driven by the same stimulus.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic ucast;
    logic mcast;
    logic bcast;
  } rxf_flags_t;
endpackage

// File: rtl/rxf_addr_regs.sv
module rxf_addr_regs #(
  parameter int REG_W      = 32,
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int VALID_BIT  = 31
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_lo,
  input  logic                                wr_hi,
  input  logic [REG_W-1:0]                    wdata,
  output logic [ADDR_BYTES-1:0][BYTE_W-1:0]   addr_bytes,
  output logic                                addr_valid
);
  localparam int LO_BYTES = REG_W / BYTE_W;
  localparam int HI_BYTES = ADDR_BYTES - LO_BYTES;
  localparam int HI_BITS  = HI_BYTES * BYTE_W;

  logic [REG_W-1:0]   lo_q;
  logic [HI_BITS-1:0] hi_q;
  logic               vld_q;
  logic               unused_hi_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) begin
        hi_q  <= wdata[HI_BITS-1:0];
        vld_q <= wdata[VALID_BIT];
      end
    end
  end

  assign unused_hi_bits = ^wdata[VALID_BIT-1:HI_BITS];
  assign addr_valid     = vld_q;

  // earliest wire byte sits in the least significant lane
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    if (g < LO_BYTES) begin : g_lo
      assign addr_bytes[g] = lo_q[g*BYTE_W +: BYTE_W];
    end else begin : g_hi
      assign addr_bytes[g] = hi_q[(g-LO_BYTES)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/rxf_byte_tracker.sv
module rxf_byte_tracker #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic [CNT_W-1:0] idx
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             start, cont;

  always_comb begin
    start = in_valid & in_sof;
    cont  = in_valid & ~in_sof & active_q & (cnt_q < CNT_W'(ADDR_BYTES));
    take  = start | cont;
    first = start;
    idx   = start ? '0 : cnt_q;
    last  = take & (idx == CNT_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (take) begin
      cnt_q    <= idx + 1'b1;
      active_q <= ~in_eof;
    end else if (in_valid & in_eof) begin
      active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_compare.sv
module rxf_compare
  import rxf_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              take,
  input  logic                              first,
  input  logic                              last,
  input  logic [CNT_W-1:0]                  idx,
  input  logic [BYTE_W-1:0]                 data,
  input  logic [ADDR_BYTES-1:0][BYTE_W-1:0] addr_bytes,
  input  logic                              addr_valid,
  output logic                              res_valid,
  output rxf_flags_t                        res_flags
);
  logic [BYTE_W-1:0] sel;
  logic uc_q, bc_q, mc_q;
  logic uc_now, bc_now, mc_now;

  always_comb begin
    sel = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (idx == CNT_W'(i)) sel = addr_bytes[i];
    uc_now = (first | uc_q) & (data == sel);
    bc_now = (first | bc_q) & (&data);
    mc_now = first ? data[0] : mc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uc_q      <= 1'b0;
      bc_q      <= 1'b0;
      mc_q      <= 1'b0;
      res_valid <= 1'b0;
      res_flags <= '0;
    end else begin
      if (take) begin
        uc_q <= uc_now;
        bc_q <= bc_now;
        mc_q <= mc_now;
      end
      res_valid <= last;
      if (last) begin
        res_flags.ucast <= uc_now & addr_valid;
        res_flags.mcast <= mc_now;
        res_flags.bcast <= bc_now;
      end else begin
        res_flags <= '0;
      end
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int VALID_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_lo,
  input  logic              cfg_wr_hi,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              res_valid,
  output logic              res_ucast,
  output logic              res_mcast,
  output logic              res_bcast
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [ADDR_BYTES-1:0][BYTE_W-1:0] addr_bytes;
  logic                              addr_valid;
  logic                              take, first, last;
  logic [CNT_W-1:0]                  idx;
  rxf_flags_t                        flags;

  rxf_addr_regs #(
    .REG_W(REG_W), .BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES), .VALID_BIT(VALID_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_lo(cfg_wr_lo), .wr_hi(cfg_wr_hi), .wdata(cfg_wdata),
    .addr_bytes(addr_bytes), .addr_valid(addr_valid)
  );

  rxf_byte_tracker #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .take(take), .first(first), .last(last), .idx(idx)
  );

  rxf_compare #(.BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk(clk), .rst(rst), .take(take), .first(first), .last(last), .idx(idx),
    .data(in_byte), .addr_bytes(addr_bytes), .addr_valid(addr_valid),
    .res_valid(res_valid), .res_flags(flags)
  );

  assign res_ucast = flags.ucast;
  assign res_mcast = flags.mcast;
  assign res_bcast = flags.bcast;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic addr_valid,
  input logic res_valid,
  input logic res_ucast,
  input logic res_mcast,
  input logic res_bcast
);
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_quiet_flags_r6: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_ucast || res_mcast || res_bcast));

  p_strobe_after_byte_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid));

  p_bcast_is_mcast_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_bcast) |-> res_mcast);

  p_invalid_no_ucast_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(addr_valid)) |-> !res_ucast);

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);
endmodule

bind rx_dest_filter rxf_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .addr_valid(addr_valid),
  .res_valid(res_valid), .res_ucast(res_ucast), .res_mcast(res_mcast), .res_bcast(res_bcast)
);

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr_lo, cfg_wr_hi;
  logic [31:0] cfg_wdata;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_byte;
  logic        res_valid, res_ucast, res_mcast, res_bcast;

  always #4 clk = ~clk;

  rx_dest_filter u_dut (
    .clk(clk), .rst(rst), .cfg_wr_lo(cfg_wr_lo), .cfg_wr_hi(cfg_wr_hi), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte),
    .res_valid(res_valid), .res_ucast(res_ucast), .res_mcast(res_mcast), .res_bcast(res_bcast)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R10";

  logic [7:0] st [6];
  bit         st_valid;
  bit         m_active;
  int         m_cnt;
  logic [7:0] m_bytes [6];
  bit         pend, p_uc, p_mc, p_bc;
  logic [7:0] fr [16];

  function automatic bit calc_bc();
    bit r = 1'b1;
    for (int k = 0; k < 6; k++) if (m_bytes[k] != 8'hFF) r = 1'b0;
    return r;
  endfunction

  function automatic bit calc_uc();
    bit r = st_valid;
    for (int k = 0; k < 6; k++) if (m_bytes[k] != st[k]) r = 1'b0;
    return r;
  endfunction

  task automatic sample_check();
    logic [3:0] act, exp;
    act = {res_valid, res_ucast, res_mcast, res_bcast};
    exp = {pend, pend & p_uc, pend & p_mc, pend & p_bc};
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: {valid,ucast,mcast,bcast} actual %b expected %b", cur_req, act, exp);
    end
  endtask

  task automatic step(bit v, bit s, bit e, logic [7:0] d);
    bit tk;
    int ix;
    @(negedge clk);
    sample_check();
    cfg_wr_lo = 1'b0; cfg_wr_hi = 1'b0;
    in_valid = v; in_sof = s; in_eof = e; in_byte = d;
    pend = 1'b0;
    tk = v && (s || (m_active && m_cnt < 6));
    ix = s ? 0 : m_cnt;
    if (tk) begin
      m_bytes[ix] = d;
      m_cnt = ix + 1;
      m_active = 1'b1;
      if (ix == 5) begin
        pend = 1'b1;
        p_uc = calc_uc();
        p_bc = calc_bc();
        p_mc = m_bytes[0][0];
      end
    end
    if (v && e) m_active = 1'b0;
  endtask

  task automatic wr_reg(bit hi, logic [31:0] w);
    @(negedge clk);
    sample_check();
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    cfg_wr_lo = !hi; cfg_wr_hi = hi; cfg_wdata = w;
    pend = 1'b0;
    if (hi) begin
      st[4] = w[7:0]; st[5] = w[15:8]; st_valid = w[31];
    end else begin
      for (int k = 0; k < 4; k++) st[k] = w[8*k +: 8];
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'($urandom % 2), 1'b0, 8'($urandom));
  endtask

  task automatic send(int n, int gmax);
    for (int i = 0; i < n; i++) begin
      int g = (gmax > 0) ? int'($urandom % (gmax + 1)) : 0;
      for (int j = 0; j < g; j++) step(1'b0, 1'($urandom % 2), 1'b0, 8'($urandom));
      step(1'b1, i == 0, i == n - 1, fr[i]);
    end
    idle(2);
  endtask

  task automatic load_station();
    for (int k = 0; k < 6; k++) fr[k] = st[k];
    for (int k = 6; k < 16; k++) fr[k] = 8'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cfg_wr_lo = 1'b0; cfg_wr_hi = 1'b0; cfg_wdata = '0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_byte = '0;
    for (int k = 0; k < 6; k++) begin st[k] = '0; m_bytes[k] = '0; end
    st_valid = 0; m_active = 0; m_cnt = 0; pend = 0; p_uc = 0; p_mc = 0; p_bc = 0;
    repeat (3) @(posedge clk);
    // R10: outputs low during reset
    @(negedge clk);
    sample_check();
    rst = 1'b0;

    // R10: reset left low word zero; setting only the valid bit matches an all-zero address
    cur_req = "R10";
    wr_reg(1'b1, 32'h8000_0000);
    for (int k = 0; k < 16; k++) fr[k] = 8'h00;
    send(8, 0);

    // R1: example wire order 00 AA 00 11 22 33
    cur_req = "R1";
    wr_reg(1'b0, 32'h1100_AA00);
    wr_reg(1'b1, 32'h8000_3322);
    fr[0] = 8'h00; fr[1] = 8'hAA; fr[2] = 8'h00; fr[3] = 8'h11; fr[4] = 8'h22; fr[5] = 8'h33;
    for (int k = 6; k < 16; k++) fr[k] = 8'($urandom);
    send(10, 0);
    // R1: reversed byte order must not match
    fr[0] = 8'h33; fr[1] = 8'h22; fr[2] = 8'h11; fr[3] = 8'h00; fr[4] = 8'hAA; fr[5] = 8'h00;
    send(10, 0);

    // R3: any single-bit difference in any byte clears the match
    cur_req = "R3";
    wr_reg(1'b0, 32'h4433_2210);
    wr_reg(1'b1, 32'h8000_6655);
    for (int k = 0; k < 6; k++) begin
      load_station();
      fr[k] = fr[k] ^ (8'h01 << ($urandom % 8));
      send(8, 1);
    end
    load_station();
    send(8, 2);

    // R2: valid bit clear blocks the match
    cur_req = "R2";
    wr_reg(1'b1, 32'h0000_6655);
    load_station();
    send(8, 0);
    wr_reg(1'b1, 32'h8000_6655);

    // R4: multicast bit
    cur_req = "R4";
    for (int k = 0; k < 16; k++) fr[k] = 8'($urandom);
    fr[0] = 8'h01; send(7, 0);
    fr[0] = 8'hFE; send(7, 0);

    // R5: broadcast and near-broadcast
    cur_req = "R5";
    for (int k = 0; k < 16; k++) fr[k] = 8'hFF;
    send(9, 1);
    fr[5] = 8'hFE; send(9, 0);

    // R7: truncated frames give no strobe; a six-byte frame still does
    cur_req = "R7";
    load_station();
    for (int n = 1; n <= 6; n++) send(n, 1);

    // R8: restart in the middle of an unfinished frame
    cur_req = "R8";
    load_station();
    step(1'b1, 1'b1, 1'b0, 8'hFF);
    step(1'b1, 1'b0, 1'b0, 8'hFF);
    step(1'b1, 1'b0, 1'b0, 8'hFF);
    send(8, 0);

    // R9: stray bytes after a frame ended, and bytes past the sixth
    cur_req = "R9";
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0, st[i % 6]);
    load_station();
    send(16, 3);

    // R6: random traffic, strobe timing and flags checked every cycle
    cur_req = "R6";
    for (int t = 0; t < 300; t++) begin
      int n = 1 + int'($urandom % 12);
      if ($urandom % 3 == 0) load_station();
      else for (int k = 0; k < 16; k++) fr[k] = 8'($urandom);
      if ($urandom % 8 == 0) for (int k = 0; k < 6; k++) fr[k] = 8'hFF;
      send(n, int'($urandom % 3));
    end

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule